// File: doc/BRIEF.md
# Accuracy-Configurable Timing-Error Filter

This block sits between the per-bit timing-error sensor flags of a 32-bit single-precision floating-point pipeline stage and the unit that replays faulty operations. For each valid operation it reduces the 32 flags to three one-cycle verdicts:

- a replay request for errors that must be corrected;
- a raw error flag that reports any detected error;
- a masked-only pulse for operations whose errors were all tolerated.

In accurate mode every flag counts toward a replay. In approximate mode, flags on the lowest N fraction bits are ignored, so small deviations in the least significant part of the fraction pass through without paying the replay cost. The word layout is fixed: bit 31 is the sign, bits 30..23 are the exponent and bits 22..0 are the fraction. Sign and exponent flags always count, in every mode and for every N.

Software selects the mode and N through a single write-only configuration register on a simple address/data write port. The setting may change between any two operations. An operation presented in the same cycle as a configuration write is judged under the setting that was in force before the write. The clock is never altered; the replay request is the only correction mechanism.

Top module: `tef_filter`

## Requirements
- R1: After reset all three outputs are 0, the mode is accurate and N is 0.
- R2: In accurate mode (configuration bit 8 = 0), `replay_req` is 1 in the cycle after a valid operation whose flag word has any bit set, and 0 otherwise.
- R3: In approximate mode (configuration bit 8 = 1), flags on fraction bits 0..N-1 do not cause `replay_req`; any flag on a bit at position N or above does cause it.
- R4: A flag on any of bits 31..23 (sign and exponent) causes `replay_req` in every mode and for every N.
- R5: N is taken from configuration bits 4..0; a written value above 23 is stored as 23, so with N written as 31, bit 22 is masked and bit 23 is not.
- R6: `raw_err` is 1 in the cycle after a valid operation whose flag word has any bit set, regardless of mode or N.
- R7: `masked_only` is 1 in the cycle after a valid operation exactly when `raw_err` is 1 and `replay_req` is 0.
- R8: An operation presented in the same cycle as a configuration write is judged under the previous configuration; the new one applies from the next operation.
- R9: A configuration write whose address is not 0 changes nothing.
- R10: In the cycle after `op_valid` is 0, all three outputs are 0, whatever the flags.
- R11: Approximate mode with N = 0 gives the same verdicts as accurate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration write address; the register is at address 0 |
| cfg_wdata | input | 32 | Write data: bits 4..0 = N, bit 8 = approximate mode |
| op_valid | input | 1 | The flag word belongs to a valid operation |
| err_flags | input | 32 | Per-bit timing-error flags of the result word |
| replay_req | output | 1 | Replay request for unmasked errors, one cycle after the operation |
| raw_err | output | 1 | Any error flag was set, one cycle after the operation |
| masked_only | output | 1 | Errors were present but every one was masked |

## Verification
The hardest situation to reach is a configuration write and a valid operation in the same cycle. The stimulus must also carry a flag that the old and the new setting judge differently. The bench provokes this on purpose: it switches from approximate to accurate while a bit-0 flag is in flight, and it expects a masked-only verdict followed by a replay on the next identical operation. A long random phase then mixes writes to both the live and dead addresses, clamped and unclamped N values, and flag words focused near the N boundary. The behavioural model judges every cycle.

// File: rtl/tef_pkg.sv
package tef_pkg;

    typedef enum logic {
        MODE_ACCURATE = 1'b0,
        MODE_APPROX   = 1'b1
    } tef_mode_e;

    typedef struct packed {
        logic replay;
        logic raw;
        logic masked_only;
    } tef_verdict_t;

endpackage

// File: rtl/tef_cfg_reg.sv
module tef_cfg_reg #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int CFG_ADDR   = 0,
    parameter int FRAC_W     = 23,
    parameter int NW         = 5,
    parameter int APPROX_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output tef_pkg::tef_mode_e mode,
    output logic [NW-1:0]     n_bits
);
    import tef_pkg::*;

    localparam logic [NW-1:0] N_MAX = NW'(FRAC_W);

    typedef struct packed {
        tef_mode_e     mode;
        logic [NW-1:0] n;
    } cfg_s;

    cfg_s cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^{wdata[DATA_W-1:APPROX_BIT+1], wdata[APPROX_BIT-1:NW]};

    always_comb begin
        cfg_d = cfg_q;
        if (we && (addr == ADDR_W'(CFG_ADDR))) begin
            cfg_d.mode = tef_mode_e'(wdata[APPROX_BIT]);
            cfg_d.n    = (wdata[NW-1:0] > N_MAX) ? N_MAX : wdata[NW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= MODE_ACCURATE;
            cfg_q.n    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode   = cfg_q.mode;
    assign n_bits = cfg_q.n;

endmodule

// File: rtl/tef_mask_gen.sv
module tef_mask_gen #(
    parameter int FRAC_W = 23,
    parameter int NW     = 5
) (
    input  logic              approx,
    input  logic [NW-1:0]     n_bits,
    output logic [FRAC_W-1:0] frac_mask
);

    for (genvar i = 0; i < FRAC_W; i++) begin : g_bit
        assign frac_mask[i] = approx && (n_bits > NW'(i));
    end

endmodule

// File: rtl/tef_filter.sv
module tef_filter #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              op_valid,
    input  logic [31:0]       err_flags,
    output logic              replay_req,
    output logic              raw_err,
    output logic              masked_only
);
    import tef_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int HIGH_W = WORD_W - FRAC_W;
    localparam int NW     = $clog2(FRAC_W + 1);

    tef_mode_e         cfg_mode;
    logic              cfg_approx;
    logic [NW-1:0]     cfg_n;
    logic [FRAC_W-1:0] frac_mask;
    logic [WORD_W-1:0] word_mask;
    tef_verdict_t      vrd_d, vrd_q;

    tef_cfg_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CFG_ADDR  (0),
        .FRAC_W    (FRAC_W),
        .NW        (NW),
        .APPROX_BIT(8)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .mode  (cfg_mode),
        .n_bits(cfg_n)
    );

    assign cfg_approx = (cfg_mode == MODE_APPROX);

    tef_mask_gen #(
        .FRAC_W(FRAC_W),
        .NW    (NW)
    ) u_mask (
        .approx   (cfg_approx),
        .n_bits   (cfg_n),
        .frac_mask(frac_mask)
    );

    assign word_mask = {{HIGH_W{1'b0}}, frac_mask};

    always_comb begin
        vrd_d = '0;
        if (op_valid) begin
            vrd_d.raw         = |err_flags;
            vrd_d.replay      = |(err_flags & ~word_mask);
            vrd_d.masked_only = vrd_d.raw && !vrd_d.replay;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vrd_q <= '0;
        end else begin
            vrd_q <= vrd_d;
        end
    end

    assign replay_req  = vrd_q.replay;
    assign raw_err     = vrd_q.raw;
    assign masked_only = vrd_q.masked_only;

endmodule

// File: rtl/tef_filter_chk.sv
module tef_filter_chk #(
    parameter int FRAC_W = 23,
    parameter int NW     = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [31:0]   err_flags,
    input logic          cfg_approx,
    input logic [NW-1:0] cfg_n,
    input logic          replay_req,
    input logic          raw_err,
    input logic          masked_only
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!replay_req && !raw_err && !masked_only)); // R1

    AST_ACCURATE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cfg_approx && (|err_flags)) |=> replay_req); // R2

    AST_HIGH_FIELD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (|err_flags[31:FRAC_W])) |=> replay_req); // R4

    AST_N_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_n <= NW'(FRAC_W)); // R5

    AST_REPLAY_IMPLIES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        replay_req |-> raw_err); // R6

    AST_MASKED_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(masked_only && replay_req)); // R7

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!replay_req && !raw_err && !masked_only)); // R10

endmodule

bind tef_filter tef_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .err_flags  (err_flags),
    .cfg_approx (cfg_approx),
    .cfg_n      (cfg_n),
    .replay_req (replay_req),
    .raw_err    (raw_err),
    .masked_only(masked_only)
);

// File: tb/tef_filter_test.sv
module tef_filter_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        op_valid = 1'b0;
    logic [31:0] err_flags = '0;
    logic        replay_req, raw_err, masked_only;

    int vectors = 0;
    int miscompares = 0;

    // behavioural model state
    bit ref_approx = 1'b0;
    int ref_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tef_filter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .op_valid   (op_valid),
        .err_flags  (err_flags),
        .replay_req (replay_req),
        .raw_err    (raw_err),
        .masked_only(masked_only)
    );

    task automatic compare(string tag, bit er, bit ew, bit em);
        vectors++;
        if (replay_req !== er || raw_err !== ew || masked_only !== em) begin
            miscompares++;
            $display("FAIL %s: replay/raw/masked actual %b%b%b expected %b%b%b",
                     tag, replay_req, raw_err, masked_only, er, ew, em);
        end
    endtask

    // one clock: drive at negedge, judge with the model, compare at next negedge
    task automatic step(string tag, bit we, logic [3:0] addr, logic [31:0] wd,
                        bit valid, logic [31:0] flags);
        bit er, ew, em;
        cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
        op_valid = valid; err_flags = flags;
        ew = valid && (flags != 0);
        er = 1'b0;
        for (int i = 0; i < 32; i++) begin
            bool_masked_check: begin
                bit msk;
                msk = ref_approx && (i < 23) && (i < ref_n);
                if (valid && flags[i] && !msk) er = 1'b1;
            end
        end
        em = ew && !er;
        @(posedge clk);
        if (we && addr == 4'd0) begin
            ref_approx = wd[8];
            ref_n = (int'(wd[4:0]) > 23) ? 23 : int'(wd[4:0]);
        end
        @(negedge clk);
        compare(tag, er, ew, em);
    endtask

    task automatic op(string tag, logic [31:0] flags);
        step(tag, 1'b0, 4'd0, 32'd0, 1'b1, flags);
    endtask

    task automatic wcfg(string tag, logic [3:0] addr, bit approx, logic [4:0] n);
        logic [31:0] wd;
        wd = 32'd0;
        wd[8] = approx;
        wd[4:0] = n;
        step(tag, 1'b1, addr, wd, 1'b0, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 outputs in reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 outputs after reset", 1'b0, 1'b0, 1'b0);
        op("R1 default accurate mode, bit 0", 32'h0000_0001);

        op("R2 accurate bit 22", 32'h0040_0000);
        op("R2 accurate no flags", 32'h0000_0000);
        op("R6 accurate many flags", 32'hA5A5_0F0F);
        op("R4 accurate sign bit", 32'h8000_0000);
        step("R10 idle with flags", 1'b0, 4'd0, 32'd0, 1'b0, 32'hFFFF_FFFF);

        wcfg("R3 set approx N=10", 4'd0, 1'b1, 5'd10);
        op("R3 bit 9 masked", 32'h0000_0200);
        op("R7 low bits only masked", 32'h0000_03FF);
        op("R3 bit 10 replays", 32'h0000_0400);
        op("R4 exponent with masked bit", 32'h4000_0001);
        op("R6 raw with masked flags", 32'h0000_0005);

        wcfg("R5 write N=31", 4'd0, 1'b1, 5'd31);
        op("R5 bit 22 masked after clamp", 32'h0040_0000);
        op("R5 bit 23 replays after clamp", 32'h0080_0000);
        op("R4 full fraction masked, exponent kept", 32'h7FFF_FFFF);

        wcfg("R9 write to dead address", 4'd1, 1'b0, 5'd0);
        op("R9 mode unchanged, bit 0 masked", 32'h0000_0001);

        step("R8 write accurate with op in flight", 1'b1, 4'd0, 32'h0000_0000,
             1'b1, 32'h0000_0001);
        op("R8 new setting applies next op", 32'h0000_0001);

        wcfg("R11 approx N=0", 4'd0, 1'b1, 5'd0);
        op("R11 bit 0 replays with N=0", 32'h0000_0001);
        op("R11 no flags with N=0", 32'h0000_0000);

        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                wcfg("R3 random config", 4'($urandom_range(0, 2)), 1'($urandom),
                     5'($urandom));
            end else if (sel == 1) begin
                step("R10 random idle", 1'b0, 4'd0, 32'd0, 1'b0, $urandom);
            end else if (sel == 2) begin
                step("R8 random write with op", 1'b1, 4'd0,
                     {23'd0, 1'($urandom), 3'd0, 5'($urandom)}, 1'b1, $urandom);
            end else begin
                logic [31:0] f;
                f = 32'd1 << $urandom_range(0, 31);
                if (sel > 6) f = f | (32'd1 << $urandom_range(0, 31));
                if (sel == 9) f = 32'd0;
                op("R3 random op", f);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule